// File: doc/BRIEF.md
# Register Rename Table with Branch Checkpoints

This block holds the mapping from architectural register numbers to physical register tags for an out-of-order core. The decode-and-insert stage uses it. Three lookup ports return the current mapping combinationally. A single update port installs a new mapping for a renamed destination, and the new mapping becomes visible on the next cycle.

The block keeps one checkpoint slot for each in-flight branch tag, and each slot holds a full copy of the table. When a branch is inserted, the live table is copied into the slot the branch tag names, and that copy includes any update made in the same cycle. When the branch mispredicts, the live table is overwritten from that slot. Taking and restoring may happen in the same cycle. Because the two never name the same tag, the restore always reads the slot's earlier contents, and no forwarding path is needed. Free-list handling and physical register storage sit outside this block.

Top module: `rename_snapshot_table`

## Requirements
- R1: After reset, every architectural register i reads as physical tag i, and every checkpoint slot holds the same identity mapping.
- R2: The three lookup ports are independent. Each returns, in the same cycle, the live mapping of the architectural index on that port, and all three may address the same or different registers.
- R3: An update with enable high and a nonzero architectural index changes that register's mapping to the given physical tag from the next cycle on. All other registers keep their mappings.
- R4: Architectural register 0 always reads as physical tag 0. An update that names index 0 changes nothing.
- R5: A take with tag t writes into slot t the live table with that cycle's update applied. Slots other than t are left unchanged.
- R6: A restore with tag t makes the live table equal to slot t's contents from the next cycle on.
- R7: When a restore and an update occur in the same cycle, the restore wins and the update is lost.
- R8: When a take and a restore occur in the same cycle on different tags, the take stores the updated live table and the restore loads the earlier contents of its own slot.
- R9: A slot's contents change only when a take names it. Updates and restores leave all slots unchanged.
- R10: A take and a restore in the same cycle never name the same tag. This is a usage rule on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to clk_i |
| upd_en_i | input | 1 | Install a new mapping |
| upd_arch_i | input | $clog2(ARCH_REGS) | Architectural register being renamed |
| upd_phys_i | input | $clog2(PHYS_REGS) | Physical tag assigned to it |
| take_en_i | input | 1 | Copy the table into a checkpoint slot |
| take_tag_i | input | $clog2(NUM_TAGS) | Branch tag naming the slot to fill |
| rest_en_i | input | 1 | Reload the live table from a checkpoint slot |
| rest_tag_i | input | $clog2(NUM_TAGS) | Branch tag naming the slot to reload from |
| rd_arch_i | input | NUM_RD x $clog2(ARCH_REGS) | Architectural index for each lookup port |
| rd_phys_o | output | NUM_RD x $clog2(PHYS_REGS) | Physical tag returned by each lookup port |

## Verification
The bench builds the block with 32 architectural registers, 64 physical tags and 8 checkpoint slots. With this many slots, a take on one tag can fall in the same cycle as a restore on another tag while several older checkpoints are still held, so slot isolation is tested against more than one neighbouring slot. Because there are 64 physical tags, the random phase can assign tags above 31, which the reset mapping never uses, and this makes stale values easy to tell apart from fresh ones. Directed sequences cover writes to register 0, a restore that coincides with an update, and a take and restore in the same cycle. A long random phase then compares every lookup port with a behavioural model on every cycle.

// File: rtl/rnm_pkg.sv
`timescale 1ns/1ps
package rnm_pkg;
  localparam int unsigned DEF_ARCH_REGS = 32;
  localparam int unsigned DEF_PHYS_REGS = 64;
  localparam int unsigned DEF_NUM_TAGS  = 4;
  localparam int unsigned DEF_NUM_RD    = 3;

  // Field width for a count, never below one bit.
  function automatic int unsigned idx_width(input int unsigned count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/rnm_live_table.sv
`timescale 1ns/1ps
module rnm_live_table #(
  parameter int unsigned AR = 32,
  parameter int unsigned PW = 6,
  parameter int unsigned AW = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      upd_en_i,
  input  logic [AW-1:0]             upd_arch_i,
  input  logic [PW-1:0]             upd_phys_i,
  input  logic                      rest_en_i,
  input  logic [AR-1:0][PW-1:0]     rest_map_i,
  output logic [AR-1:0][PW-1:0]     upd_map_o,
  output logic [AR-1:0][PW-1:0]     live_q_o
);
  logic [AR-1:0][PW-1:0] live_q, live_d;
  logic                  upd_ok, live_we;

  // Register 0 is never remapped.
  assign upd_ok = upd_en_i && (upd_arch_i != '0);

  always_comb begin
    upd_map_o = live_q;
    if (upd_ok) upd_map_o[upd_arch_i] = upd_phys_i;
  end

  // Restore has priority over an update in the same cycle.
  always_comb begin
    live_d  = rest_en_i ? rest_map_i : upd_map_o;
    live_we = rest_en_i | upd_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(AR); i++) live_q[i] <= PW'(i);
    end else if (live_we) begin
      live_q <= live_d;
    end
  end

  assign live_q_o = live_q;
endmodule

// File: rtl/rnm_snap_bank.sv
`timescale 1ns/1ps
module rnm_snap_bank #(
  parameter int unsigned AR = 32,
  parameter int unsigned PW = 6,
  parameter int unsigned NT = 4,
  parameter int unsigned TW = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          take_en_i,
  input  logic [TW-1:0]                 take_tag_i,
  input  logic [AR-1:0][PW-1:0]         take_map_i,
  input  logic [TW-1:0]                 rest_tag_i,
  output logic [AR-1:0][PW-1:0]         rest_map_o,
  output logic [NT-1:0][AR-1:0][PW-1:0] snap_q_o
);
  logic [NT-1:0][AR-1:0][PW-1:0] slot_q;
  logic [NT-1:0]                 slot_we;

  for (genvar g = 0; g < int'(NT); g++) begin : g_slot
    assign slot_we[g] = take_en_i && (take_tag_i == TW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < int'(AR); i++) slot_q[g][i] <= PW'(i);
      end else if (slot_we[g]) begin
        slot_q[g] <= take_map_i;
      end
    end
  end

  // The restore reads the registered contents, so the slot being taken in the
  // same cycle is never forwarded (the two tags differ by rule).
  always_comb begin
    rest_map_o = slot_q[0];
    for (int s = 0; s < int'(NT); s++)
      if (rest_tag_i == TW'(s)) rest_map_o = slot_q[s];
  end

  assign snap_q_o = slot_q;
endmodule

// File: rtl/rnm_read_port.sv
`timescale 1ns/1ps
module rnm_read_port #(
  parameter int unsigned AR = 32,
  parameter int unsigned PW = 6,
  parameter int unsigned AW = 5
) (
  input  logic [AR-1:0][PW-1:0] map_i,
  input  logic [AW-1:0]         arch_i,
  output logic [PW-1:0]         phys_o
);
  assign phys_o = map_i[arch_i];
endmodule

// File: rtl/rename_snapshot_table.sv
`timescale 1ns/1ps
module rename_snapshot_table
  import rnm_pkg::*;
#(
  parameter int unsigned ARCH_REGS = DEF_ARCH_REGS,
  parameter int unsigned PHYS_REGS = DEF_PHYS_REGS,
  parameter int unsigned NUM_TAGS  = DEF_NUM_TAGS,
  parameter int unsigned NUM_RD    = DEF_NUM_RD,
  localparam int unsigned AW = idx_width(ARCH_REGS),
  localparam int unsigned PW = idx_width(PHYS_REGS),
  localparam int unsigned TW = idx_width(NUM_TAGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     upd_en_i,
  input  logic [AW-1:0]            upd_arch_i,
  input  logic [PW-1:0]            upd_phys_i,
  input  logic                     take_en_i,
  input  logic [TW-1:0]            take_tag_i,
  input  logic                     rest_en_i,
  input  logic [TW-1:0]            rest_tag_i,
  input  logic [NUM_RD-1:0][AW-1:0] rd_arch_i,
  output logic [NUM_RD-1:0][PW-1:0] rd_phys_o
);
  logic [ARCH_REGS-1:0][PW-1:0]               live_map, upd_map, rest_map;
  logic [NUM_TAGS-1:0][ARCH_REGS-1:0][PW-1:0] snap_map;

  rnm_live_table #(.AR(ARCH_REGS), .PW(PW), .AW(AW)) live_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_en_i   (upd_en_i),
    .upd_arch_i (upd_arch_i),
    .upd_phys_i (upd_phys_i),
    .rest_en_i  (rest_en_i),
    .rest_map_i (rest_map),
    .upd_map_o  (upd_map),
    .live_q_o   (live_map)
  );

  rnm_snap_bank #(.AR(ARCH_REGS), .PW(PW), .NT(NUM_TAGS), .TW(TW)) snap_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_en_i  (take_en_i),
    .take_tag_i (take_tag_i),
    .take_map_i (upd_map),
    .rest_tag_i (rest_tag_i),
    .rest_map_o (rest_map),
    .snap_q_o   (snap_map)
  );

  for (genvar k = 0; k < int'(NUM_RD); k++) begin : g_rd
    rnm_read_port #(.AR(ARCH_REGS), .PW(PW), .AW(AW)) port_i (
      .map_i  (live_map),
      .arch_i (rd_arch_i[k]),
      .phys_o (rd_phys_o[k])
    );
  end
endmodule

// File: rtl/rnm_chk.sv
`timescale 1ns/1ps
module rnm_chk #(
  parameter int unsigned ARCH_REGS = 32,
  parameter int unsigned NUM_TAGS  = 4,
  parameter int unsigned NUM_RD    = 3,
  parameter int unsigned AW = 5,
  parameter int unsigned PW = 6,
  parameter int unsigned TW = 2
) (
  input logic                                    clk_i,
  input logic                                    rst_ni,
  input logic                                    upd_en_i,
  input logic [AW-1:0]                           upd_arch_i,
  input logic [PW-1:0]                           upd_phys_i,
  input logic                                    take_en_i,
  input logic [TW-1:0]                           take_tag_i,
  input logic                                    rest_en_i,
  input logic [TW-1:0]                           rest_tag_i,
  input logic [NUM_RD-1:0][AW-1:0]               rd_arch_i,
  input logic [NUM_RD-1:0][PW-1:0]               rd_phys_o,
  input logic [ARCH_REGS-1:0][PW-1:0]            live_map,
  input logic [NUM_TAGS-1:0][ARCH_REGS-1:0][PW-1:0] snap_map
);
  for (genvar k = 0; k < int'(NUM_RD); k++) begin : g_zero
    // R4
    r4_zero_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_arch_i[k] == '0) |-> (rd_phys_o[k] == '0));
    // R2
    r2_port_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_phys_o[k] == live_map[rd_arch_i[k]]);
  end

  // R3
  r3_update_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !rest_en_i && upd_arch_i != '0) |=>
      live_map[$past(upd_arch_i)] == $past(upd_phys_i));

  // R6
  r6_restore_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rest_en_i |=> live_map == $past(snap_map[rest_tag_i]));

  // R5
  r5_take_copies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_en_i && !upd_en_i) |=> snap_map[$past(take_tag_i)] == $past(live_map));

  // R9
  r9_slots_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_en_i |=> $stable(snap_map));

  // R10
  r10_tag_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_en_i && rest_en_i) |-> (take_tag_i != rest_tag_i));
endmodule

bind rename_snapshot_table rnm_chk #(
  .ARCH_REGS(ARCH_REGS), .NUM_TAGS(NUM_TAGS), .NUM_RD(NUM_RD),
  .AW(AW), .PW(PW), .TW(TW)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .upd_en_i   (upd_en_i),
  .upd_arch_i (upd_arch_i),
  .upd_phys_i (upd_phys_i),
  .take_en_i  (take_en_i),
  .take_tag_i (take_tag_i),
  .rest_en_i  (rest_en_i),
  .rest_tag_i (rest_tag_i),
  .rd_arch_i  (rd_arch_i),
  .rd_phys_o  (rd_phys_o),
  .live_map   (live_map),
  .snap_map   (snap_map)
);

// File: tb/rename_snapshot_table_tb.sv
`timescale 1ns/1ps
module rename_snapshot_table_tb_top;
  localparam int AR = 32;
  localparam int PR = 64;
  localparam int NT = 8;
  localparam int NR = 3;
  localparam int AW = 5;
  localparam int PW = 6;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_en = 1'b0, take_en = 1'b0, rest_en = 1'b0;
  logic [AW-1:0] upd_arch = '0;
  logic [PW-1:0] upd_phys = '0;
  logic [TW-1:0] take_tag = '0, rest_tag = '0;
  logic [NR-1:0][AW-1:0] rd_arch = '0;
  logic [NR-1:0][PW-1:0] rd_phys;

  int checks = 0;
  int fails  = 0;
  int model_live [AR];
  int model_snap [NT][AR];

  always #2 clk = ~clk;

  rename_snapshot_table #(.ARCH_REGS(AR), .PHYS_REGS(PR), .NUM_TAGS(NT), .NUM_RD(NR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .upd_en_i(upd_en), .upd_arch_i(upd_arch), .upd_phys_i(upd_phys),
    .take_en_i(take_en), .take_tag_i(take_tag),
    .rest_en_i(rest_en), .rest_tag_i(rest_tag),
    .rd_arch_i(rd_arch), .rd_phys_o(rd_phys)
  );

  // Compare each lookup port against the model's current table.
  task automatic compare(input string req);
    for (int k = 0; k < NR; k++) begin
      checks++;
      if (int'(rd_phys[k]) != model_live[rd_arch[k]]) begin
        fails++;
        $display("FAIL %s port %0d arch %0d: got %0d expected %0d",
                 req, k, rd_arch[k], rd_phys[k], model_live[rd_arch[k]]);
      end
    end
  endtask

  // One cycle: apply inputs, check reads, clock, then advance the model.
  task automatic cyc(input bit u, input int a, input int p,
                     input bit t, input int tt, input bit r, input int rt,
                     input int q0, input int q1, input int q2, input string req);
    int tmp [AR];
    int src [AR];
    upd_en = u; upd_arch = AW'(a); upd_phys = PW'(p);
    take_en = t; take_tag = TW'(tt); rest_en = r; rest_tag = TW'(rt);
    rd_arch[0] = AW'(q0); rd_arch[1] = AW'(q1); rd_arch[2] = AW'(q2);
    #1;
    compare(req);
    @(posedge clk);
    tmp = model_live;
    if (u && a != 0) tmp[a] = p;
    src = model_snap[rt];
    if (t) model_snap[tt] = tmp;
    model_live = r ? src : tmp;
    @(negedge clk);
  endtask

  task automatic idle_read(input int q0, input int q1, input int q2, input string req);
    cyc(0, 0, 0, 0, 0, 0, 0, q0, q1, q2, req);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < AR; i++) begin
      model_live[i] = i;
      for (int s = 0; s < NT; s++) model_snap[s][i] = i;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: identity after reset
    for (int i = 0; i < AR; i += 3) idle_read(i, (i + 1) % AR, (i + 2) % AR, "R1");
    // R1: slot identity seen through a restore
    cyc(0, 0, 0, 0, 0, 1, 5, 7, 8, 9, "R1");
    idle_read(7, 30, 31, "R1");

    // R3: updates land next cycle
    cyc(1, 3, 40, 0, 0, 0, 0, 3, 4, 5, "R3");
    idle_read(3, 4, 5, "R3");
    cyc(1, 4, 50, 0, 0, 0, 0, 3, 4, 4, "R3");
    // R2: three ports, same and different indices
    idle_read(4, 4, 3, "R2");
    idle_read(31, 3, 1, "R2");

    // R4: r0 writes ignored
    cyc(1, 0, 55, 0, 0, 0, 0, 0, 0, 0, "R4");
    idle_read(0, 0, 3, "R4");

    // R5: take includes same-cycle update
    cyc(1, 5, 41, 1, 1, 0, 0, 5, 6, 7, "R5");
    cyc(1, 5, 42, 0, 0, 0, 0, 5, 6, 7, "R5");
    // R6: restore slot 1 -> r5 back to 41
    cyc(0, 0, 0, 0, 0, 1, 1, 5, 3, 4, "R6");
    idle_read(5, 3, 4, "R6");

    // R7: restore beats update
    cyc(1, 9, 60, 0, 0, 1, 1, 9, 5, 0, "R7");
    idle_read(9, 5, 0, "R7");

    // R8: take tag 2 with update, restore tag 1 in the same cycle
    cyc(1, 6, 33, 0, 0, 0, 0, 6, 5, 0, "R8");
    cyc(1, 7, 34, 1, 2, 1, 1, 6, 7, 5, "R8");
    idle_read(6, 7, 5, "R8");
    cyc(0, 0, 0, 0, 0, 1, 2, 6, 7, 5, "R8");
    idle_read(6, 7, 5, "R8");

    // R9: slot 3 untouched by later updates and restores
    cyc(1, 10, 61, 1, 3, 0, 0, 10, 11, 12, "R9");
    cyc(1, 10, 62, 0, 0, 0, 0, 10, 11, 12, "R9");
    cyc(1, 11, 63, 0, 0, 1, 2, 10, 11, 12, "R9");
    cyc(0, 0, 0, 0, 0, 1, 3, 10, 11, 12, "R9");
    idle_read(10, 11, 12, "R9");

    // R10: random traffic, take and restore tags always distinct
    for (int n = 0; n < 3000; n++) begin
      int tt, rt;
      bit t, r;
      tt = $urandom_range(NT - 1);
      rt = $urandom_range(NT - 1);
      t = ($urandom_range(3) == 0);
      r = ($urandom_range(5) == 0);
      if (t && r && tt == rt) rt = (rt + 1) % NT;
      cyc($urandom_range(1), $urandom_range(AR - 1), $urandom_range(PR - 1),
          t, tt, r, rt,
          $urandom_range(AR - 1), $urandom_range(AR - 1), $urandom_range(AR - 1),
          "R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule